// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block walks a ring of receive descriptors kept in a small local word memory. Each descriptor takes four consecutive 32-bit words. Word 0 is status, word 1 is control, word 2 is the first buffer address and word 3 is the second buffer address or link. Software prepares descriptors through a host port and hands each one to the engine by setting the top status bit. The engine completes one descriptor for every frame that arrives. A frame arrives as a single-cycle pulse that carries its length.

On each frame the engine looks at the descriptor under its pointer. If hardware owns that descriptor, the engine does four things in the same clock edge:

- writes the length into the status word,
- gives ownership back to software,
- raises a frame-done flag,
- moves the pointer on, either to the ring base, along the link, or to the next four-word slot.

If software still holds the descriptor, the engine raises a no-buffer flag, counts a missed frame and suspends. A poll request makes it look at the same descriptor again. Turning reception off parks the pointer on the ring base.

Top module: `rxr_ring_engine`

## Requirements
- R1: After reset, the status byte is 0, the missed count is 0, the engine is not suspended and the current descriptor address is 0.
- R2: While `rx_en` is low, the current descriptor address takes the ring base value, the engine leaves suspension, and frames change neither memory, status nor the missed count.
- R3: A frame that meets a hardware-owned descriptor (status bit 31 = 1) while running rewrites that status word to the frame length in bits 26:16 with every other bit 0, which clears bit 31. It also sets status byte bit 6.
- R4: After a completed frame, the next descriptor is chosen as follows, in this order of precedence. Control bit 25 set sends the engine to the ring base. Otherwise control bit 24 set sends it to the address in the low bits of word 3. Otherwise it moves to the current address plus 4, wrapping modulo the memory depth.
- R5: A frame that meets a software-owned descriptor while running writes nothing and keeps the pointer. It sets status byte bit 7, adds one to the missed count and suspends the engine.
- R6: While suspended, every frame is counted as missed and sets bit 7, and no descriptor is written, even if the descriptor is now owned by hardware.
- R7: A poll request while suspended resumes the engine if the current descriptor is hardware-owned, and leaves it suspended otherwise. A frame in the same cycle keeps it suspended.
- R8: Writing the status byte clears every bit written as 1. A flag raised in the same cycle wins over its clear. Only bits 6 and 7 can be nonzero.
- R9: The missed count saturates at its maximum value.
- R10: `host_rdata` shows the memory word at `host_addr`. A host write lands on the next edge, and an engine write to the same word in that edge takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Reception enable |
| base_we | input | 1 | Load the ring base register |
| base_wdata | input | AW | Ring base word address |
| poll_dmd | input | 1 | Poll request: recheck the current descriptor |
| sts_clr_we | input | 1 | Status byte write-one-to-clear strobe |
| sts_clr_data | input | 8 | Bits to clear |
| host_we | input | 1 | Host memory write |
| host_addr | input | AW | Host memory word address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Memory word at host_addr |
| frm_vld | input | 1 | Frame-end pulse |
| frm_len | input | 11 | Frame length including CRC |
| sts_o | output | 8 | Status byte: bit 6 frame done, bit 7 no buffer |
| missed_o | output | MISS_W | Missed frame count |
| suspended_o | output | 1 | Engine suspended |
| cur_desc_o | output | AW | Current descriptor word address |

## Verification
The assertions check properties on every cycle:

- the pointer follows the base while reception is off,
- a miss holds the pointer and suspends the engine,
- a completed frame raises the done flag,
- a poll on an owned descriptor resumes the engine,
- the missed count never wraps back to zero.

Only the bench's scenarios can show the rest. These are the exact contents written into the status word, the precedence of end-of-ring over the link, wrap to the base, write-one-to-clear races, and the way host handoffs interleave with frames. The bench compares all of these against a reference model built from the requirements, under directed ring walks and seeded random traffic.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

    localparam int OWN_BIT  = 31;
    localparam int EOR_BIT  = 25;
    localparam int CHN_BIT  = 24;
    localparam int LEN_LSB  = 16;
    localparam int LEN_W    = 11;
    localparam int DONE_BIT = 6;
    localparam int UNAV_BIT = 7;
    localparam logic [7:0] STS_MASK = 8'hC0;

    typedef enum logic {ST_RUN, ST_SUSP} eng_state_e;

    typedef struct packed {
        logic        own;
        logic        eor;
        logic        chn;
        logic [31:0] link;
    } desc_flags_t;

    function automatic logic [31:0] rxr_status_word(input logic [LEN_W-1:0] len);
        logic [31:0] w;
        w = '0;
        w[LEN_LSB +: LEN_W] = len;
        return w;
    endfunction

    function automatic logic [31:0] rxr_next_desc(input logic [31:0] cur,
                                                  input logic [31:0] base,
                                                  input desc_flags_t d);
        if (d.eor)      return base;
        else if (d.chn) return d.link;
        else            return cur + 32'd4;
    endfunction

endpackage

// File: rtl/rxr_desc_mem.sv
module rxr_desc_mem
    import rxr_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          host_we,
    input  logic [AW-1:0] host_addr,
    input  logic [31:0]   host_wdata,
    output logic [31:0]   host_rdata,
    input  logic          eng_we,
    input  logic [AW-1:0] eng_waddr,
    input  logic [31:0]   eng_wdata,
    input  logic [AW-1:0] desc_ptr,
    output desc_flags_t   desc_flags
);
    localparam int DEPTH = 1 << AW;

    logic [31:0] mem_q [DEPTH];
    logic [AW-1:0] a_ctl, a_lnk;

    assign a_ctl = desc_ptr + AW'(1);
    assign a_lnk = desc_ptr + AW'(3);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            if (host_we) mem_q[host_addr] <= host_wdata;
            if (eng_we)  mem_q[eng_waddr] <= eng_wdata;   // engine wins (R10)
        end
    end

    assign host_rdata      = mem_q[host_addr];
    assign desc_flags.own  = mem_q[desc_ptr][OWN_BIT];
    assign desc_flags.eor  = mem_q[a_ctl][EOR_BIT];
    assign desc_flags.chn  = mem_q[a_ctl][CHN_BIT];
    assign desc_flags.link = mem_q[a_lnk];

endmodule

// File: rtl/rxr_ctrl.sv
module rxr_ctrl
    import rxr_pkg::*;
#(
    parameter int AW     = 6,
    parameter int MISS_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_en,
    input  logic              base_we,
    input  logic [AW-1:0]     base_wdata,
    input  logic              poll_dmd,
    input  logic              sts_clr_we,
    input  logic [7:0]        sts_clr_data,
    input  logic              frm_vld,
    input  logic [LEN_W-1:0]  frm_len,
    input  desc_flags_t       desc_flags,
    output logic              eng_we,
    output logic [AW-1:0]     eng_waddr,
    output logic [31:0]       eng_wdata,
    output logic [AW-1:0]     ptr_o,
    output logic [7:0]        sts_o,
    output logic [MISS_W-1:0] missed_o,
    output logic              suspended_o
);
    localparam logic [MISS_W-1:0] MISS_MAX = {MISS_W{1'b1}};

    logic [AW-1:0]     base_q, ptr_q, ptr_nxt;
    eng_state_e        state_q;
    logic [7:0]        sts_q, sts_set, sts_clr;
    logic [MISS_W-1:0] miss_q;
    logic              take, miss, resume;

    assign take   = rx_en && frm_vld && (state_q == ST_RUN) && desc_flags.own;
    assign miss   = rx_en && frm_vld && !take;
    assign resume = rx_en && (state_q == ST_SUSP) && poll_dmd && desc_flags.own;

    assign ptr_nxt = AW'(rxr_next_desc(32'(ptr_q), 32'(base_q), desc_flags));

    always_comb begin
        sts_set = '0;
        sts_set[DONE_BIT] = take;
        sts_set[UNAV_BIT] = miss;
        sts_clr = sts_clr_we ? sts_clr_data : 8'h00;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q  <= '0;
            ptr_q   <= '0;
            state_q <= ST_RUN;
            sts_q   <= '0;
            miss_q  <= '0;
        end else begin
            if (base_we) base_q <= base_wdata;
            if (!rx_en) begin
                ptr_q   <= base_q;
                state_q <= ST_RUN;
            end else begin
                if (take)        ptr_q   <= ptr_nxt;
                if (miss)        state_q <= ST_SUSP;
                else if (resume) state_q <= ST_RUN;
            end
            sts_q <= ((sts_q & ~sts_clr) | sts_set) & STS_MASK;
            if (miss && (miss_q != MISS_MAX)) miss_q <= miss_q + MISS_W'(1);
        end
    end

    assign eng_we      = take;
    assign eng_waddr   = ptr_q;
    assign eng_wdata   = rxr_status_word(frm_len);
    assign ptr_o       = ptr_q;
    assign sts_o       = sts_q;
    assign missed_o    = miss_q;
    assign suspended_o = (state_q == ST_SUSP);

    a_r2_ptr_follows_base: assert property (@(posedge clk) disable iff (rst)
        !rx_en |=> (ptr_q == $past(base_q)));
    a_r3_done_flag: assert property (@(posedge clk) disable iff (rst)
        take |=> sts_q[DONE_BIT]);
    a_r5_hold_on_miss: assert property (@(posedge clk) disable iff (rst)
        (miss && state_q == ST_RUN) |=> ($stable(ptr_q) && state_q == ST_SUSP));
    a_r7_poll_resume: assert property (@(posedge clk) disable iff (rst)
        (resume && !frm_vld) |=> (state_q == ST_RUN));
    a_r9_no_wrap: assert property (@(posedge clk) disable iff (rst)
        (miss_q != '0) |=> (miss_q != '0));

endmodule

// File: rtl/rxr_ring_engine.sv
module rxr_ring_engine
    import rxr_pkg::*;
#(
    parameter int AW     = 6,
    parameter int MISS_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_en,
    input  logic              base_we,
    input  logic [AW-1:0]     base_wdata,
    input  logic              poll_dmd,
    input  logic              sts_clr_we,
    input  logic [7:0]        sts_clr_data,
    input  logic              host_we,
    input  logic [AW-1:0]     host_addr,
    input  logic [31:0]       host_wdata,
    output logic [31:0]       host_rdata,
    input  logic              frm_vld,
    input  logic [10:0]       frm_len,
    output logic [7:0]        sts_o,
    output logic [MISS_W-1:0] missed_o,
    output logic              suspended_o,
    output logic [AW-1:0]     cur_desc_o
);
    desc_flags_t   flags;
    logic          eng_we;
    logic [AW-1:0] eng_waddr, ptr;
    logic [31:0]   eng_wdata;

    rxr_desc_mem #(.AW(AW)) u_mem (
        .clk(clk), .rst(rst),
        .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata),
        .eng_we(eng_we), .eng_waddr(eng_waddr), .eng_wdata(eng_wdata),
        .desc_ptr(ptr), .desc_flags(flags)
    );

    rxr_ctrl #(.AW(AW), .MISS_W(MISS_W)) u_ctrl (
        .clk(clk), .rst(rst), .rx_en(rx_en),
        .base_we(base_we), .base_wdata(base_wdata), .poll_dmd(poll_dmd),
        .sts_clr_we(sts_clr_we), .sts_clr_data(sts_clr_data),
        .frm_vld(frm_vld), .frm_len(frm_len), .desc_flags(flags),
        .eng_we(eng_we), .eng_waddr(eng_waddr), .eng_wdata(eng_wdata),
        .ptr_o(ptr), .sts_o(sts_o), .missed_o(missed_o),
        .suspended_o(suspended_o)
    );

    assign cur_desc_o = ptr;

endmodule

// File: tb/rxr_ring_engine_tb_top.sv
module rxr_ring_engine_tb_top;
    localparam int AW = 6;
    localparam int MW = 4;
    localparam int DEPTH = 1 << AW;

    logic clk = 0, rst = 1;
    logic rx_en = 0, base_we = 0, poll_dmd = 0, sts_clr_we = 0, host_we = 0, frm_vld = 0;
    logic [AW-1:0] base_wdata = '0, host_addr = '0;
    logic [7:0] sts_clr_data = '0;
    logic [31:0] host_wdata = '0, host_rdata;
    logic [10:0] frm_len = '0;
    logic [7:0] sts_o;
    logic [MW-1:0] missed_o;
    logic suspended_o;
    logic [AW-1:0] cur_desc_o;

    int errors = 0, checks = 0;

    // reference model state
    logic [31:0] m_mem [DEPTH];
    logic [AW-1:0] m_base, m_ptr;
    logic m_susp;
    logic [7:0] m_sts;
    logic [MW-1:0] m_miss;

    always #2 clk = ~clk;

    rxr_ring_engine #(.AW(AW), .MISS_W(MW)) dut_i (
        .clk(clk), .rst(rst), .rx_en(rx_en), .base_we(base_we), .base_wdata(base_wdata),
        .poll_dmd(poll_dmd), .sts_clr_we(sts_clr_we), .sts_clr_data(sts_clr_data),
        .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .frm_vld(frm_vld), .frm_len(frm_len), .sts_o(sts_o),
        .missed_o(missed_o), .suspended_o(suspended_o), .cur_desc_o(cur_desc_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_status(input logic [10:0] len);
        return {5'b0, len, 16'h0};
    endfunction

    function automatic logic [AW-1:0] exp_next(input logic [AW-1:0] p);
        logic [31:0] c;
        c = m_mem[AW'(p + 1)];
        if (c[25])      return m_base;
        else if (c[24]) return m_mem[AW'(p + 3)][AW-1:0];
        else            return AW'(p + 4);
    endfunction

    // one clock: model the edge, then compare all outputs
    task automatic step();
        logic own, take, miss, resume;
        logic [AW-1:0] n_ptr;
        logic n_susp;
        logic [7:0] set, clr;
        own    = m_mem[m_ptr][31];
        take   = rx_en && frm_vld && !m_susp && own;
        miss   = rx_en && frm_vld && !take;
        resume = rx_en && m_susp && poll_dmd && own;
        n_ptr  = !rx_en ? m_base : (take ? exp_next(m_ptr) : m_ptr);
        n_susp = !rx_en ? 1'b0 : (miss ? 1'b1 : (resume ? 1'b0 : m_susp));
        set = {miss, take, 6'b0};
        clr = sts_clr_we ? sts_clr_data : 8'h00;
        @(posedge clk);
        if (host_we) m_mem[host_addr] = host_wdata;
        if (take)    m_mem[m_ptr] = exp_status(frm_len);
        if (base_we) m_base = base_wdata;
        m_ptr  = n_ptr;
        m_susp = n_susp;
        m_sts  = ((m_sts & ~clr) | set) & 8'hC0;
        if (miss && m_miss != '1) m_miss = m_miss + 1'b1;
        @(negedge clk);
        check("R4 cur_desc", 32'(cur_desc_o), 32'(m_ptr));
        check("R3/R8 sts", 32'(sts_o), 32'(m_sts));
        check("R5/R9 missed", 32'(missed_o), 32'(m_miss));
        check("R7 suspended", 32'(suspended_o), 32'(m_susp));
        check("R10 host_rdata", host_rdata, m_mem[host_addr]);
        base_we = 0; poll_dmd = 0; sts_clr_we = 0; host_we = 0; frm_vld = 0;
    endtask

    task automatic hwr(input logic [AW-1:0] a, input logic [31:0] d);
        host_we = 1; host_addr = a; host_wdata = d; step();
    endtask

    task automatic frame(input logic [10:0] len);
        frm_vld = 1; frm_len = len; step();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
        m_base = '0; m_ptr = '0; m_susp = 0; m_sts = '0; m_miss = '0;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        check("R1 sts", 32'(sts_o), 0);
        check("R1 missed", 32'(missed_o), 0);
        check("R1 suspended", 32'(suspended_o), 0);
        check("R1 cur_desc", 32'(cur_desc_o), 0);
        // build ring: 8 -> 12 -> (link) 32 -> (end of ring beats link) 8
        hwr(6'd8,  32'h8000_0000); hwr(6'd9,  32'h0000_0600);
        hwr(6'd12, 32'h8000_0000); hwr(6'd13, 32'h0100_0600); hwr(6'd15, 32'd32);
        hwr(6'd32, 32'h8000_0000); hwr(6'd33, 32'h0300_0600); hwr(6'd35, 32'd12);
        base_we = 1; base_wdata = 6'd8; step();
        step();
        check("R2 ptr at base", 32'(cur_desc_o), 8);
        host_addr = 6'd8; frame(11'd100);
        check("R2 frame ignored", host_rdata, 32'h8000_0000);
        check("R2 no flag", 32'(sts_o), 0);
        rx_en = 1; step();
        frame(11'd64);
        check("R3 status word", host_rdata, 32'h0040_0000);
        check("R4 sequential", 32'(cur_desc_o), 12);
        frame(11'd1518);
        check("R4 chained", 32'(cur_desc_o), 32);
        frame(11'd60);
        check("R4 end of ring wins", 32'(cur_desc_o), 8);
        frame(11'd70);
        check("R5 suspended", 32'(suspended_o), 1);
        check("R5 ptr held", 32'(cur_desc_o), 8);
        hwr(6'd8, 32'h8000_0000);
        frame(11'd80);
        check("R6 no write", host_rdata, 32'h8000_0000);
        check("R6 missed", 32'(missed_o), 2);
        hwr(6'd8, 32'h0);
        poll_dmd = 1; step();
        check("R7 stays suspended", 32'(suspended_o), 1);
        hwr(6'd8, 32'h8000_0000);
        poll_dmd = 1; step();
        check("R7 resumed", 32'(suspended_o), 0);
        sts_clr_we = 1; sts_clr_data = 8'h40; step();
        check("R8 clear bit6", 32'(sts_o), 32'h80);
        frame(11'd90);
        sts_clr_we = 1; sts_clr_data = 8'hFF; frm_vld = 1; frm_len = 11'd5; step();
        check("R8 set beats clear", 32'(sts_o), 32'h80);
        repeat (20) frame(11'd33);
        check("R9 saturated", 32'(missed_o), 15);
        // random traffic
        for (int n = 0; n < 600; n++) begin
            int r;
            r = $urandom_range(0, 99);
            if (r < 3) rx_en = ~rx_en;
            frm_vld = ($urandom_range(0, 2) == 0);
            frm_len = 11'($urandom_range(60, 1536));
            poll_dmd = ($urandom_range(0, 3) == 0);
            if ($urandom_range(0, 9) == 0) begin sts_clr_we = 1; sts_clr_data = 8'($urandom); end
            host_addr = 6'($urandom_range(0, DEPTH - 1));
            if ($urandom_range(0, 2) == 0) begin
                host_we = 1;
                case ($urandom_range(0, 2))
                    0: host_addr = 6'd8;
                    1: host_addr = 6'd12;
                    default: host_addr = 6'd32;
                endcase
                host_wdata = 32'h8000_0000;
            end
            step();
        end
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule